// File: doc/BRIEF.md
# ADC Serial Master Readout Engine

This block is the digital output side of a 16-bit successive-approximation converter set to serial master mode. A start pulse opens a conversion window of fixed length, and `busy_o` is high for that window. The analog conversion itself is modelled: the window ends by capturing the word presented on `result_i`. The block makes its own serial clock, a frame strobe and an MSB-first data stream, so a host only has to sample.

A run-time mode input picks when a result leaves the block. In one timing, a frame starts when the conversion ends and carries the word just converted. In the other, a frame starts with the next conversion and carries the result of the conversion before it. Chip select and read enable gate the serial pins. Two polarity inputs invert the serial clock and the frame strobe.

The serial output is a fixed-timing push stream with no back-pressure. The host cannot stall a frame. A frame that is gated off by chip select or read enable is lost to the host, but the conversion and the result capture still happen. Timing is in system clocks: the conversion lasts `CONV_CYCLES` cycles, and one serial clock period is `SCLK_DIV` cycles, of which the low half comes first.

Top module: `adc_serial_master`

## Requirements
- R1: The block is enabled only when `ser_sel_i` is 1 and `int_clk_n_i` is 0. When it is not enabled, a start pulse does not begin a conversion, `busy_o` stays 0, and the serial pins stay idle: `sdata_o` is 0, `sclk_o` equals `inv_sclk_i`, and `sync_o` equals `inv_sync_i`.
- R2: A start pulse accepted on a clock edge makes `busy_o` 1 from that edge for exactly `CONV_CYCLES` cycles.
- R3: A frame lasts 17 serial clock periods. The strobe is active for the whole frame. The first period is a lead-in with no clock pulse, and the next 16 periods each carry exactly one serial clock pulse. Outside a frame the serial clock stays at its idle level.
- R4: The data bits go out MSB first, one bit per serial clock period. Each bit holds through both the low half and the high half of its period, so it changes only where the non-inverted serial clock falls. `sdata_o` is 0 during the lead-in.
- R5: With `read_after_i` = 1, the frame begins on the edge where `busy_o` falls. It carries the word on `result_i` at that edge.
- R6: With `read_after_i` = 0, the frame begins on the edge where `busy_o` rises. It carries the word captured at the end of the previous conversion.
- R7: In read-during-conversion mode, the first frame after reset carries 16 zero bits and still has all 16 clock pulses.
- R8: While `cs_n_i` or `rd_n_i` is 1, the serial pins are idle. The conversion and the result capture go on unchanged.
- R9: The non-inverted serial clock idles at 0 and the non-inverted strobe is active-high. `sclk_o` is the internal clock XOR `inv_sclk_i`, and `sync_o` is the internal strobe XOR `inv_sync_i`.
- R10: A start pulse is ignored while `busy_o` is 1 or a frame is still in progress.
- R11: After reset `busy_o` is 0, the serial pins are idle and the stored previous result is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start-conversion pulse |
| result_i | input | 16 | Conversion result, captured when the window ends |
| ser_sel_i | input | 1 | 1 selects serial operation |
| int_clk_n_i | input | 1 | 0 selects the internally generated serial clock |
| read_after_i | input | 1 | 1: read after conversion; 0: read previous result during conversion |
| cs_n_i | input | 1 | Active-low chip select |
| rd_n_i | input | 1 | Active-low read enable |
| inv_sclk_i | input | 1 | Inverts the serial clock |
| inv_sync_i | input | 1 | Inverts the frame strobe |
| busy_o | output | 1 | High during the conversion window |
| sclk_o | output | 1 | Generated serial clock |
| sync_o | output | 1 | Frame strobe |
| sdata_o | output | 1 | Serial data, MSB first |

## Verification
Two cases are hard to reach from the ports. The first is the overlap where a start pulse arrives after `busy_o` has fallen but while a read-during-conversion frame is still shifting its last bit. With the default divider, that frame outlasts the conversion by two cycles. The bench puts a start pulse on that exact edge and checks that neither `busy_o` nor the serial pins react. The second is the carried-over word: a gated or disabled frame must still update, or leave alone, the word the next overlapped frame sends. The bench keeps its own model of the previous result. It runs sweeps over both modes, all four polarity settings and walking-one words, and predicts every pin in every cycle.

// File: rtl/adc_ser_pkg.sv
package adc_ser_pkg;
  typedef enum logic [1:0] {
    FR_IDLE  = 2'd0,
    FR_LEAD  = 2'd1,
    FR_SHIFT = 2'd2
  } frame_state_e;
endpackage

// File: rtl/adc_conv_timer.sv
module adc_conv_timer #(
  parameter int CONV_CYCLES = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go_i,
  output logic busy_o,
  output logic done_o
);
  localparam int CNT_W = (CONV_CYCLES > 2) ? $clog2(CONV_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CONV_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (cnt_q == LAST) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else if (go_i) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end
  end

  assign busy_o = busy_q;
  // last cycle of the window: the edge ending it also captures the result
  assign done_o = busy_q && (cnt_q == LAST);
endmodule

// File: rtl/adc_frame_shifter.sv
module adc_frame_shifter
  import adc_ser_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int SCLK_DIV = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [DATA_W-1:0] word_i,
  output logic              active_o,
  output logic              sclk_raw_o,
  output logic              sync_raw_o,
  output logic              sd_raw_o
);
  localparam int PH_W  = (SCLK_DIV > 2) ? $clog2(SCLK_DIV) : 1;
  localparam int BIT_W = $clog2(DATA_W);
  localparam int HALF  = SCLK_DIV / 2;
  localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(SCLK_DIV - 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(DATA_W - 1);

  frame_state_e      state_q;
  logic [PH_W-1:0]   ph_q;
  logic [BIT_W-1:0]  bit_q;
  logic [DATA_W-1:0] shreg_q;
  logic              ph_high;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FR_IDLE;
      ph_q    <= '0;
      bit_q   <= '0;
      shreg_q <= '0;
    end else begin
      unique case (state_q)
        FR_IDLE: begin
          if (load_i) begin
            state_q <= FR_LEAD;
            shreg_q <= word_i;
            ph_q    <= '0;
            bit_q   <= '0;
          end
        end
        FR_LEAD: begin
          if (ph_q == PH_LAST) begin
            ph_q    <= '0;
            state_q <= FR_SHIFT;
          end else begin
            ph_q <= ph_q + 1'b1;
          end
        end
        FR_SHIFT: begin
          if (ph_q == PH_LAST) begin
            ph_q    <= '0;
            shreg_q <= {shreg_q[DATA_W-2:0], 1'b0};
            if (bit_q == BIT_LAST) begin
              state_q <= FR_IDLE;
              bit_q   <= '0;
            end else begin
              bit_q <= bit_q + 1'b1;
            end
          end else begin
            ph_q <= ph_q + 1'b1;
          end
        end
        default: state_q <= FR_IDLE;
      endcase
    end
  end

  // the divider picks how the high half of a period is decoded
  generate
    if (SCLK_DIV == 2) begin : g_div2
      assign ph_high = ph_q[0];
    end else begin : g_divn
      assign ph_high = (ph_q >= PH_W'(HALF));
    end
  endgenerate

  assign active_o   = (state_q != FR_IDLE);
  assign sync_raw_o = active_o;
  assign sclk_raw_o = (state_q == FR_SHIFT) && ph_high;
  assign sd_raw_o   = (state_q == FR_SHIFT) && shreg_q[DATA_W-1];
endmodule

// File: rtl/adc_out_stage.sv
module adc_out_stage (
  input  logic enable_i,
  input  logic cs_n_i,
  input  logic rd_n_i,
  input  logic inv_sclk_i,
  input  logic inv_sync_i,
  input  logic sclk_raw_i,
  input  logic sync_raw_i,
  input  logic sd_raw_i,
  output logic sclk_o,
  output logic sync_o,
  output logic sdata_o
);
  logic gate;

  assign gate    = enable_i && !cs_n_i && !rd_n_i;
  assign sclk_o  = (gate && sclk_raw_i) ^ inv_sclk_i;
  assign sync_o  = (gate && sync_raw_i) ^ inv_sync_i;
  assign sdata_o = gate && sd_raw_i;
endmodule

// File: rtl/adc_serial_master.sv
module adc_serial_master #(
  parameter int DATA_W      = 16,
  parameter int CONV_CYCLES = 32,
  parameter int SCLK_DIV    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [DATA_W-1:0] result_i,
  input  logic              ser_sel_i,
  input  logic              int_clk_n_i,
  input  logic              read_after_i,
  input  logic              cs_n_i,
  input  logic              rd_n_i,
  input  logic              inv_sclk_i,
  input  logic              inv_sync_i,
  output logic              busy_o,
  output logic              sclk_o,
  output logic              sync_o,
  output logic              sdata_o
);
  logic              enable;
  logic              go;
  logic              conv_busy;
  logic              conv_done;
  logic              frame_active;
  logic              frame_load;
  logic [DATA_W-1:0] frame_word;
  logic [DATA_W-1:0] prev_q;
  logic              sclk_raw;
  logic              sync_raw;
  logic              sd_raw;

  assign enable = ser_sel_i && !int_clk_n_i;
  assign go     = start_i && enable && !conv_busy && !frame_active;

  adc_conv_timer #(.CONV_CYCLES(CONV_CYCLES)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .go_i   (go),
    .busy_o (conv_busy),
    .done_o (conv_done)
  );

  // result of the most recent conversion, sent by the next overlapped frame
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
    end else if (conv_done) begin
      prev_q <= result_i;
    end
  end

  assign frame_load = read_after_i ? conv_done : go;
  assign frame_word = read_after_i ? result_i : prev_q;

  adc_frame_shifter #(.DATA_W(DATA_W), .SCLK_DIV(SCLK_DIV)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (frame_load),
    .word_i     (frame_word),
    .active_o   (frame_active),
    .sclk_raw_o (sclk_raw),
    .sync_raw_o (sync_raw),
    .sd_raw_o   (sd_raw)
  );

  adc_out_stage u_out (
    .enable_i   (enable),
    .cs_n_i     (cs_n_i),
    .rd_n_i     (rd_n_i),
    .inv_sclk_i (inv_sclk_i),
    .inv_sync_i (inv_sync_i),
    .sclk_raw_i (sclk_raw),
    .sync_raw_i (sync_raw),
    .sd_raw_i   (sd_raw),
    .sclk_o     (sclk_o),
    .sync_o     (sync_o),
    .sdata_o    (sdata_o)
  );

  assign busy_o = conv_busy;
endmodule

// File: rtl/adc_serial_master_chk.sv
module adc_serial_master_chk #(
  parameter int CONV_CYCLES = 32
) (
  input logic clk,
  input logic rst_n,
  input logic ser_sel_i,
  input logic int_clk_n_i,
  input logic cs_n_i,
  input logic rd_n_i,
  input logic inv_sclk_i,
  input logic inv_sync_i,
  input logic busy_o,
  input logic sclk_o,
  input logic sync_o,
  input logic sdata_o
);
  logic [31:0] busy_run_q;
  logic        true_sclk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_run_q <= '0;
    else if (busy_o) busy_run_q <= busy_run_q + 1'b1;
    else busy_run_q <= '0;
  end

  assign true_sclk = sclk_o ^ inv_sclk_i;

  // R2: a busy window, once it closes, lasted exactly CONV_CYCLES cycles
  assert_busy_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> busy_run_q == 32'(CONV_CYCLES));

  // R3: no serial clock pulse outside an active strobe
  assert_idle_sclk_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_o == inv_sync_i) |-> (sclk_o == inv_sclk_i));

  // R4: data does not move across a rising edge of the true serial clock
  assert_data_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(true_sclk) && $stable(cs_n_i) && $stable(rd_n_i) && $stable(inv_sclk_i)
     && $stable(ser_sel_i) && $stable(int_clk_n_i)) |-> $stable(sdata_o));

  // R8: gated pins stay idle
  assert_gated_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n_i || rd_n_i) |-> (sdata_o == 1'b0 && sclk_o == inv_sclk_i && sync_o == inv_sync_i));

  // R1: disabled pins stay idle
  assert_disabled_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!ser_sel_i || int_clk_n_i) |-> (sdata_o == 1'b0 && sclk_o == inv_sclk_i));
endmodule

bind adc_serial_master adc_serial_master_chk #(.CONV_CYCLES(CONV_CYCLES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ser_sel_i   (ser_sel_i),
  .int_clk_n_i (int_clk_n_i),
  .cs_n_i      (cs_n_i),
  .rd_n_i      (rd_n_i),
  .inv_sclk_i  (inv_sclk_i),
  .inv_sync_i  (inv_sync_i),
  .busy_o      (busy_o),
  .sclk_o      (sclk_o),
  .sync_o      (sync_o),
  .sdata_o     (sdata_o)
);

// File: tb/test_adc_serial_master.sv
`timescale 1ns/1ps
module test_adc_serial_master;
  localparam int CONV = 32;
  localparam int DIV  = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [15:0] result_i = '0;
  logic        ser_sel_i = 1'b1, int_clk_n_i = 1'b0, read_after_i = 1'b0;
  logic        cs_n_i = 1'b0, rd_n_i = 1'b0, inv_sclk_i = 1'b0, inv_sync_i = 1'b0;
  logic        busy_o, sclk_o, sync_o, sdata_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [15:0] last_m = '0;

  always #4 clk = ~clk;

  adc_serial_master #(.DATA_W(16), .CONV_CYCLES(CONV), .SCLK_DIV(DIV)) i_adc_serial_master (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .result_i(result_i),
    .ser_sel_i(ser_sel_i), .int_clk_n_i(int_clk_n_i), .read_after_i(read_after_i),
    .cs_n_i(cs_n_i), .rd_n_i(rd_n_i), .inv_sclk_i(inv_sclk_i), .inv_sync_i(inv_sync_i),
    .busy_o(busy_o), .sclk_o(sclk_o), .sync_o(sync_o), .sdata_o(sdata_o)
  );

  task automatic check1(input string req, input logic got, input logic expv);
    checks++;
    if (got !== expv) begin
      errors++;
      $display("FAIL %s got %b expected %b", req, got, expv);
    end
  endtask

  // one start pulse, then predict every pin in every cycle of the frame
  task automatic run_frame(input logic [15:0] word, input int pc, input string req);
    logic en, gate;
    logic [15:0] expw;
    int base, bad_busy, bad_sync, bad_sclk, bad_data, npulse;
    logic prev_sclk;
    en   = ser_sel_i && !int_clk_n_i;
    gate = en && !cs_n_i && !rd_n_i;
    expw = read_after_i ? word : last_m;
    base = read_after_i ? CONV : 0;
    bad_busy = -1; bad_sync = -1; bad_sclk = -1; bad_data = -1;
    npulse = 0;
    prev_sclk = inv_sclk_i;
    result_i = word;
    start_i  = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int c = 0; c < CONV + 17*DIV + 2; c++) begin
      int rel;
      logic act, r_sclk, r_sd, e_busy;
      rel    = c - base;
      act    = en && rel >= 0 && rel < 17*DIV;
      r_sclk = act && rel >= DIV && ((rel - DIV) % DIV) >= DIV/2;
      r_sd   = act && rel >= DIV && expw[15 - (rel - DIV)/DIV];
      e_busy = en && c < CONV;
      if (busy_o !== e_busy && bad_busy < 0) bad_busy = c;
      if (sync_o !== ((gate && act) ^ inv_sync_i) && bad_sync < 0) bad_sync = c;
      if (sclk_o !== ((gate && r_sclk) ^ inv_sclk_i) && bad_sclk < 0) bad_sclk = c;
      if (sdata_o !== (gate && r_sd) && bad_data < 0) bad_data = c;
      if ((sclk_o ^ inv_sclk_i) && !(prev_sclk ^ inv_sclk_i)) npulse++;
      prev_sclk = sclk_o;
      if (c == pc) start_i = 1'b1;
      else if (c == pc + 1) start_i = 1'b0;
      @(negedge clk);
    end
    start_i = 1'b0;
    checks += 5;
    if (bad_busy >= 0) begin errors++; $display("FAIL %s R2 busy wrong at cycle %0d word %h", req, bad_busy, word); end
    if (bad_sync >= 0) begin errors++; $display("FAIL %s R3 sync wrong at cycle %0d word %h", req, bad_sync, word); end
    if (bad_sclk >= 0) begin errors++; $display("FAIL %s R9 sclk wrong at cycle %0d word %h", req, bad_sclk, word); end
    if (bad_data >= 0) begin errors++; $display("FAIL %s R4 data wrong at cycle %0d got word ? expected %h", req, bad_data, expw); end
    if (npulse != (gate ? 16 : 0)) begin
      errors++;
      $display("FAIL %s R3 pulses got %0d expected %0d", req, npulse, gate ? 16 : 0);
    end
    if (en) last_m = word;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    check1("R11 busy", busy_o, 1'b0);
    check1("R11 sclk", sclk_o, 1'b0);
    check1("R11 sync", sync_o, 1'b0);
    check1("R11 sdata", sdata_o, 1'b0);

    read_after_i = 1'b0;
    run_frame(16'hA5A5, -10, "R7 first overlapped frame zeros");
    run_frame(16'h1234, -10, "R6 previous result");
    read_after_i = 1'b1;
    run_frame(16'h8001, -10, "R5 read after");
    read_after_i = 1'b0;
    run_frame(16'hFFFF, -10, "R6 after mode switch");

    // R9 polarity sweep in both modes
    for (int pol = 0; pol < 4; pol++) begin
      for (int m = 0; m < 2; m++) begin
        inv_sclk_i   = pol[0];
        inv_sync_i   = pol[1];
        read_after_i = m[0];
        run_frame(16'h0F0F ^ 16'(pol * 16'h1111) ^ 16'(m * 16'h4242), -10, "R9 polarity");
      end
    end
    inv_sclk_i = 1'b0; inv_sync_i = 1'b0;

    // R4 walking ones, both modes
    for (int b = 0; b < 16; b++) begin
      read_after_i = b[0];
      run_frame(16'h0001 << b, -10, "R4 walking one");
    end

    // R8 gating: conversion still captures
    read_after_i = 1'b1; cs_n_i = 1'b1;
    run_frame(16'h3C3C, -10, "R8 cs gated");
    cs_n_i = 1'b0; read_after_i = 1'b0;
    run_frame(16'h5555, -10, "R8 word kept after cs gate");
    rd_n_i = 1'b1;
    run_frame(16'hC3C3, -10, "R8 rd gated");
    rd_n_i = 1'b0;
    run_frame(16'h0000, -10, "R8 word kept after rd gate");

    // R1 disabled: no conversion, stored word untouched
    ser_sel_i = 1'b0;
    run_frame(16'hDEAD, -10, "R1 parallel select");
    ser_sel_i = 1'b1; int_clk_n_i = 1'b1; inv_sclk_i = 1'b1;
    run_frame(16'hBEEF, -10, "R1 external clock select");
    int_clk_n_i = 1'b0; inv_sclk_i = 1'b0;
    run_frame(16'h7E7E, -10, "R1 stored word unchanged");

    // R10 start pulses ignored while busy and during frame tail
    read_after_i = 1'b1;
    run_frame(16'h9669, 5, "R10 start while busy");
    run_frame(16'h6996, CONV + 10, "R10 start during frame");
    read_after_i = 1'b0;
    run_frame(16'h1357, 5, "R10 start while busy overlapped");
    run_frame(16'h2468, 17*DIV - 2, "R10 start at frame tail");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule